// File: doc/BRIEF.md
# Pipelined Digit-Serial Two's-Complement Adder

This block adds two two's-complement words that arrive in pieces. Each clock brings one digit of each operand, least significant digit first. A digit is `DIGIT_W` bits wide, and a word is `WORD_W` bits wide, so one word takes `WORD_W/DIGIT_W` clocks. With `DIGIT_W = 1` the block is a plain bit-serial adder. `WORD_W` must be an integer multiple of `DIGIT_W`.

Inside a digit the carry ripples from the low bit to the high bit. The carry out of the top bit is stored and used by the next digit. A one-cycle pulse on `start_i` marks the least significant digit of every word. While that pulse is high, the stored carry is replaced by zero, so no carry passes from one word into the next. Words follow each other with no gap, one pulse per word. The sum digit and the stored carry both leave through registers, so each result digit appears exactly one clock after its operand digits.

A small controller has two states. `ST_IDLE` is entered at reset. The block leaves it on the first start pulse (transition IDLE→RUN). `ST_RUN` then holds (transition RUN→RUN) until the next reset (transition any→IDLE). While the controller is in `ST_IDLE` and no pulse is present, both outputs stay at zero. The controller also tracks the digit position, so that a start pulse arriving in `ST_RUN` can be checked against the word boundary.

Top module: `serial_digit_adder`

## Requirements
- R1: For every word, the `WORD_W/DIGIT_W` consecutive `sum_o` digits, least significant first, reassemble to (A + B) mod 2^WORD_W. A and B are the words presented on `a_i` and `b_i` from the cycle of the start pulse onward.
- R2: Inside a digit the carry ripples from bit 0 toward bit `DIGIT_W-1`. `carry_o` is the registered carry out of the top bit of the digit just added. After the last digit of a word, `carry_o` equals bit `WORD_W` of the unsigned sum A + B. When both operand digits are all ones, `carry_o` is 1 on the following cycle.
- R3: In a cycle where `start_i` is 1, the digit addition uses a carry-in of zero, whatever carry is stored. A carry left over from one word never reaches the next word.
- R4: Each `sum_o` digit and each `carry_o` value appears exactly one clock after the operand digits that produce them. In a running word whose operand digits are both zero, the next `sum_o` equals the carry stored before that digit.
- R5: After reset, `sum_o` and `carry_o` are zero. They stay zero in every cycle before the first start pulse, whatever is driven on `a_i` and `b_i`.
- R6: Start pulses repeat once every `WORD_W/DIGIT_W` cycles. Back-to-back words are each summed independently. A pulse seen in `ST_RUN` coincides with digit position 0 of the controller's count.
- R7: The controller goes from `ST_IDLE` to `ST_RUN` on a start pulse and stays in `ST_RUN` until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse marking the least significant digit of a word |
| a_i | input | DIGIT_W | Current digit of operand A |
| b_i | input | DIGIT_W | Current digit of operand B |
| sum_o | output | DIGIT_W | Registered sum digit, one cycle after its inputs |
| carry_o | output | 1 | Registered carry out of the digit just added |

## Verification
The assertions check these properties on every cycle:
- a start pulse with zero operand digits produces a zero digit and no carry;
- a zero digit pair inside a word passes the stored carry through to the next sum digit;
- two all-ones digits always produce a carry;
- the outputs stay quiet while the controller is idle;
- a start pulse seen while running falls on the word boundary;
- the controller never leaves `ST_RUN` without a reset.

Only the bench scenarios can show whole-word correctness: reassembling random and carry-heavy words, the final carry of each word, and isolation between back-to-back words. These scenarios are run for one-bit digits and for two-bit digits.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sadd_state_e;

endpackage

// File: rtl/serial_digit_ripple.sv
module serial_digit_ripple #(
    parameter int DIGIT_W = 1
) (
    input  logic [DIGIT_W-1:0] x_i,
    input  logic [DIGIT_W-1:0] y_i,
    input  logic               cin_i,
    output logic [DIGIT_W-1:0] s_o,
    output logic               cout_o
);

    logic [DIGIT_W:0] chain;

    assign chain[0] = cin_i;

    for (genvar g = 0; g < DIGIT_W; g++) begin : g_bit
        assign s_o[g]       = x_i[g] ^ y_i[g] ^ chain[g];
        assign chain[g + 1] = (x_i[g] & y_i[g]) | (chain[g] & (x_i[g] ^ y_i[g]));
    end

    assign cout_o = chain[DIGIT_W];

endmodule

// File: rtl/serial_word_ctrl.sv
module serial_word_ctrl
    import serial_add_pkg::*;
#(
    parameter int DIGIT_W = 1,
    parameter int WORD_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output sadd_state_e state_o,
    output logic        active_o
);

    localparam int NDIG  = WORD_W / DIGIT_W;
    localparam int CNT_W = (NDIG > 1) ? $clog2(NDIG) : 1;

    sadd_state_e state_q;
    sadd_state_e state_d;
    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o  = state_q;
        active_o = start_i || (state_q == ST_RUN);
    end

    // pos_q holds the digit index expected in the coming cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (start_i) begin
            pos_q <= (NDIG > 1) ? CNT_W'(1) : '0;
        end else if (state_q == ST_RUN) begin
            pos_q <= (pos_q == CNT_W'(NDIG - 1)) ? '0 : CNT_W'(pos_q + 1'b1);
        end
    end

    // R6: a pulse seen while running lands on the word boundary.
    a_r6_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == ST_RUN) |-> (pos_q == '0));

    // R7: the running state is left only through reset.
    a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/serial_digit_adder.sv
module serial_digit_adder
    import serial_add_pkg::*;
#(
    parameter int DIGIT_W = 1,
    parameter int WORD_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] b_i,
    output logic [DIGIT_W-1:0] sum_o,
    output logic               carry_o
);

    sadd_state_e       st;
    logic              active;
    logic              cin_sel;
    logic [DIGIT_W-1:0] dsum;
    logic              dcout;
    logic [DIGIT_W-1:0] sum_q;
    logic              carry_q;

    serial_word_ctrl #(
        .DIGIT_W (DIGIT_W),
        .WORD_W  (WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .state_o  (st),
        .active_o (active)
    );

    // R3: the start pulse replaces the stored carry with zero.
    assign cin_sel = start_i ? 1'b0 : carry_q;

    serial_digit_ripple #(
        .DIGIT_W (DIGIT_W)
    ) u_digit (
        .x_i    (a_i),
        .y_i    (b_i),
        .cin_i  (cin_sel),
        .s_o    (dsum),
        .cout_o (dcout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end else if (active) begin
            sum_q   <= dsum;
            carry_q <= dcout;
        end else begin
            sum_q   <= '0;
            carry_q <= 1'b0;
        end
    end

    assign sum_o   = sum_q;
    assign carry_o = carry_q;

    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && a_i == '0 && b_i == '0) |=> (sum_o == '0 && !carry_o));

    a_r4_carry_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start_i && a_i == '0 && b_i == '0)
        |=> (sum_o == DIGIT_W'($past(carry_o)) && !carry_o));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !start_i) |=> (sum_o == '0 && !carry_o));

    a_r2_ones_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (active && a_i == '1 && b_i == '1) |=> carry_o);

endmodule

// File: tb/serial_digit_adder_tb_top.sv
`timescale 1ns/1ps
module serial_digit_adder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       a1 = 1'b0, b1 = 1'b0;
    logic [1:0] a2 = '0, b2 = '0;
    logic       s1, c1, c2;
    logic [1:0] s2;

    int checks = 0;
    int errors = 0;

    logic [7:0]  wa1 [8];
    logic [7:0]  wb1 [8];
    logic [7:0]  ws1 [8];
    logic        wc1 [8];
    logic [15:0] wa2 [8];
    logic [15:0] wb2 [8];
    logic [15:0] ws2 [8];
    logic        wc2 [8];

    always #10 clk = ~clk;

    serial_digit_adder #(.DIGIT_W(2), .WORD_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .a_i(a2), .b_i(b2), .sum_o(s2), .carry_o(c2));

    serial_digit_adder #(.DIGIT_W(1), .WORD_W(8)) dut1_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .a_i(a1), .b_i(b1), .sum_o(s1), .carry_o(c1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0;
        a1 = 1'b0; b1 = 1'b0; a2 = '0; b2 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Streams nw back-to-back words (8 cycles each) and checks every one.
    task automatic stream(input int nw, input string tag);
        for (int cyc = 0; cyc <= nw * 8; cyc++) begin
            @(negedge clk);
            if (cyc > 0) begin
                int pw;
                int pk;
                pw = (cyc - 1) / 8;
                pk = (cyc - 1) % 8;
                ws1[pw][pk]        = s1;
                ws2[pw][2*pk +: 2] = s2;
                if (pk == 7) begin
                    wc1[pw] = c1;
                    wc2[pw] = c2;
                end
            end
            if (cyc < nw * 8) begin
                int w;
                int k;
                w = cyc / 8;
                k = cyc % 8;
                start = (k == 0);
                a1 = wa1[w][k];
                b1 = wb1[w][k];
                a2 = wa2[w][2*k +: 2];
                b2 = wb2[w][2*k +: 2];
            end else begin
                start = 1'b0;
                a1 = 1'b0; b1 = 1'b0; a2 = '0; b2 = '0;
            end
        end
        for (int w = 0; w < nw; w++) begin
            logic [8:0]  e1;
            logic [16:0] e2;
            e1 = {1'b0, wa1[w]} + {1'b0, wb1[w]};
            e2 = {1'b0, wa2[w]} + {1'b0, wb2[w]};
            chk($sformatf("R1 %s d1 word %0d sum", tag, w), 32'(ws1[w]), 32'(e1[7:0]));
            chk($sformatf("R2 %s d1 word %0d carry", tag, w), 32'(wc1[w]), 32'(e1[8]));
            chk($sformatf("R1 %s d2 word %0d sum", tag, w), 32'(ws2[w]), 32'(e2[15:0]));
            chk($sformatf("R2 %s d2 word %0d carry", tag, w), 32'(wc2[w]), 32'(e2[16]));
        end
    endtask

    // R5: quiet after reset and before any start pulse.
    task automatic t_idle();
        do_reset();
        chk("R5 reset sum d1", 32'(s1), 0);
        chk("R5 reset carry d1", 32'(c1), 0);
        chk("R5 reset sum d2", 32'(s2), 0);
        chk("R5 reset carry d2", 32'(c2), 0);
        a1 = 1'b1; b1 = 1'b1; a2 = 2'b11; b2 = 2'b11;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R5 idle ignores operands d1", {31'b0, c1} | 32'(s1), 0);
            chk("R5 idle ignores operands d2", {31'b0, c2} | 32'(s2), 0);
        end
    endtask

    // R4: one clock of delay; R2: carry ripples into the next digit.
    task automatic t_latency();
        do_reset();
        @(negedge clk);
        start = 1'b1; a1 = 1'b1; b1 = 1'b1; a2 = 2'd3; b2 = 2'd1;
        #1;
        chk("R4 no output before edge d1", 32'(s1), 0);
        chk("R4 no output before edge d2", 32'(s2), 0);
        @(negedge clk);
        chk("R4 digit0 sum d1", 32'(s1), 0);
        chk("R2 digit0 carry d1", 32'(c1), 1);
        chk("R4 digit0 sum d2", 32'(s2), 0);
        chk("R2 digit0 carry d2", 32'(c2), 1);
        start = 1'b0; a1 = 1'b0; b1 = 1'b0; a2 = '0; b2 = '0;
        @(negedge clk);
        chk("R4 carry into digit1 d1", 32'(s1), 1);
        chk("R7 carry cleared after use d1", 32'(c1), 0);
        chk("R4 carry into digit1 d2", 32'(s2), 1);
        chk("R7 carry cleared after use d2", 32'(c2), 0);
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 6; i++) begin
            wa1[i] = 8'($urandom);  wb1[i] = 8'($urandom);
            wa2[i] = 16'($urandom); wb2[i] = 16'($urandom);
        end
        stream(6, "random");
    endtask

    // R3/R6: carry-heavy words back to back must not leak into each other.
    task automatic t_carry_words();
        do_reset();
        wa1[0] = 8'hFF; wb1[0] = 8'h01; wa2[0] = 16'hFFFF; wb2[0] = 16'h0001;
        wa1[1] = 8'h00; wb1[1] = 8'h00; wa2[1] = 16'h0000; wb2[1] = 16'h0000;
        wa1[2] = 8'hFF; wb1[2] = 8'hFF; wa2[2] = 16'hFFFF; wb2[2] = 16'hFFFF;
        wa1[3] = 8'h80; wb1[3] = 8'h80; wa2[3] = 16'h8000; wb2[3] = 16'h8000;
        wa1[4] = 8'hFD; wb1[4] = 8'h05; wa2[4] = 16'hFFFD; wb2[4] = 16'h0005;
        wa1[5] = 8'h7F; wb1[5] = 8'h01; wa2[5] = 16'h7FFF; wb2[5] = 16'h0001;
        stream(6, "R3 R6 carry words");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_idle();
        t_latency();
        t_random();
        t_carry_words();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule